// File: doc/BRIEF.md
# PCI Memory Target Burst Address Tracker

This block follows one transaction at a time on a multiplexed 32-bit PCI address/data path, from the target side of a memory slave. In the clock where FRAME# first goes low the shared lines carry the address and C/BE# carries the bus command. The block registers the dword part of that address, reads the two lowest address bits as a burst-order code, and decides on its own whether the address and command select its memory window. Decode on the bus is distributed, so this decision belongs to each target.

In every data phase after that the block gives the local memory port the dword address for the current transfer. In linear-increment order it moves that address on by four bytes each time a transfer completes, so the initiator sends only one address for the whole burst. For any other order code the address stays on the first dword. The surrounding target logic then ends the transfer after one phase. When the final phase completes, the block goes back to idle and waits for the next address phase.

Top module: `pci_burst_addr_tracker`

## Requirements
- R1: While reset is applied, and until the first address phase after it, `cur_addr` reads 0 and `hit` and `burst_linear` read 0.
- R2: A clock edge in the idle state with `frame_n` low is an address phase. From the next clock on, `cur_addr` equals `ad` of that edge with bits 1..0 forced to 0.
- R3: `burst_linear` is 1 during the data phases of a transaction whose address-phase `ad[1:0]` was 2'b00, and 0 for any other code and in idle.
- R4: In linear order, each clock edge in a data phase with `irdy_n` and `trdy_n` both low raises `cur_addr` by 4 from the next clock.
- R5: A data-phase edge where `irdy_n` or `trdy_n` is high leaves `cur_addr` unchanged.
- R6: For a non-zero burst-order code, `cur_addr` stays on the captured dword whatever transfers complete.
- R7: `hit` is 1 in the clock after the address phase exactly when two things are true. The command on `cbe_n` is a memory command: 4'b0110, 4'b0111, 4'b1100, 4'b1110 or 4'b1111. The address bits above the window size match the window base.
- R8: `hit` is re-evaluated for every new `cur_addr`, and drops to 0 once a linear burst steps out of the window.
- R9: A completed transfer with `frame_n` high ends the transaction. From the next clock `hit` and `burst_linear` are 0 and `cur_addr` holds its last value until the next address phase, which may follow straight away.
- R10: For a non-memory command, `hit` stays 0 for the whole transaction, while the address is still tracked per R4.
- R11: The address step wraps modulo 2^32, so 32'hFFFF_FFFC advances to 32'h0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 32 | Multiplexed address/data lines |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| cur_addr | output | 32 | Byte address of the current dword transfer |
| hit | output | 1 | Current address and command select this target's window |
| burst_linear | output | 1 | Transaction uses linear-increment burst order |

## Verification
The bench inserts wait states from either side in the middle of a burst. A tracker that advanced on IRDY# alone would run ahead of the data. It also places a linear burst across the top edge of the window, where a hit latched only at the address phase would keep claiming addresses that belong to another target. Further cases are a non-zero order code, where an incrementing design would write the wrong dwords, and an address phase that follows the final transfer with no gap, which catches a design that needs an idle clock. It also covers a burst wrapping past the top of the address space and an I/O command inside the window, which a design that ignores the command would wrongly claim. A random stream of transactions is then compared against a behavioural model on every clock.

// File: rtl/pcitrk_pkg.sv
package pcitrk_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } phase_e;

  localparam logic [1:0] ORDER_LINEAR = 2'b00;

  // Memory-space commands a memory target answers to.
  function automatic logic is_mem_cmd(input logic [3:0] cmd);
    case (cmd)
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 1'b1;
      default:                                     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pcitrk_rst_sync.sv
module pcitrk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/pcitrk_phase_fsm.sv
module pcitrk_phase_fsm
  import pcitrk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_n,
  input  logic   xfer,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   load,
  output logic   fin
);

  always_comb begin
    phase_d = phase_q;
    load    = 1'b0;
    fin     = 1'b0;
    case (phase_q)
      ST_IDLE: begin
        if (!frame_n) begin
          load    = 1'b1;
          phase_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (xfer && frame_n) begin
          fin     = 1'b1;
          phase_d = ST_IDLE;
        end
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= ST_IDLE;
    else        phase_q <= phase_d;
  end

  // R9: the final completed transfer returns the tracker to idle
  p_end_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_DATA && xfer && frame_n) |=> (phase_q == ST_IDLE));

  // R2: an address phase always leads into a data phase
  p_addr_to_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_IDLE && !frame_n) |=> (phase_q == ST_DATA));

endmodule

// File: rtl/pcitrk_addr_gen.sv
module pcitrk_addr_gen
  import pcitrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int DW_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              fin,
  input  logic              in_data,
  input  logic              xfer,
  input  logic [ADDR_W-1:0] ad,
  output logic [DW_W-1:0]   dw_d,
  output logic [DW_W-1:0]   dw_q,
  output logic              lin_q
);

  logic lin_d;
  logic step_en;
  logic upd_en;

  assign step_en = in_data && xfer;
  assign upd_en  = load || step_en;

  always_comb begin
    dw_d  = dw_q;
    lin_d = lin_q;
    if (load) begin
      dw_d  = ad[ADDR_W-1:2];
      lin_d = (ad[1:0] == ORDER_LINEAR);
    end else if (step_en) begin
      if (lin_q) dw_d = dw_q + DW_W'(1);
      if (fin)   lin_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dw_q  <= '0;
      lin_q <= 1'b0;
    end else if (upd_en) begin
      dw_q  <= dw_d;
      lin_q <= lin_d;
    end
  end

  // R4, R11: one dword per completed linear transfer, wrapping at the top
  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && xfer && lin_q) |=> (dw_q == $past(dw_q) + DW_W'(1)));

  // R5: wait states freeze the address
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !xfer) |=> $stable(dw_q));

  // R6: non-linear order never moves off the first dword
  p_nonlinear_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !lin_q) |=> $stable(dw_q));

endmodule

// File: rtl/pcitrk_window_dec.sv
module pcitrk_window_dec
  import pcitrk_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter int              WIN_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              in_data_d,
  output logic              hit_q
);

  localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_LOG2;
  localparam logic [ADDR_W-1:0] BASE_TAG = WIN_BASE & WIN_MASK;

  logic mem_q;
  logic mem_d;
  logic in_win;
  logic hit_d;

  assign mem_d  = load ? is_mem_cmd(cmd) : mem_q;
  assign in_win = ((addr_d & WIN_MASK) == BASE_TAG);
  assign hit_d  = in_data_d && mem_d && in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= 1'b0;
    else if (load) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  // R10: a claim needs a memory command captured at the address phase
  p_hit_needs_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> mem_q);

endmodule

// File: rtl/pci_burst_addr_tracker.sv
module pci_burst_addr_tracker
  import pcitrk_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h4000_0000,
  parameter int                WIN_LOG2   = 12,
  parameter int                RST_STAGES = 2,
  localparam int               DW_W       = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic [3:0]        cbe_n,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              hit,
  output logic              burst_linear
);

  logic        srst_n;
  logic        xfer;
  phase_e      phase_q;
  phase_e      phase_d;
  logic        load;
  logic        fin;
  logic [DW_W-1:0] dw_d;
  logic [DW_W-1:0] dw_q;
  logic        lin_q;

  assign xfer = !irdy_n && !trdy_n;

  pcitrk_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pcitrk_phase_fsm u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .frame_n (frame_n),
    .xfer    (xfer),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .load    (load),
    .fin     (fin)
  );

  pcitrk_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (load),
    .fin     (fin),
    .in_data (phase_q == ST_DATA),
    .xfer    (xfer),
    .ad      (ad),
    .dw_d    (dw_d),
    .dw_q    (dw_q),
    .lin_q   (lin_q)
  );

  pcitrk_window_dec #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_LOG2 (WIN_LOG2)
  ) u_win (
    .clk       (clk),
    .rst_n     (srst_n),
    .load      (load),
    .cmd       (cbe_n),
    .addr_d    ({dw_d, 2'b00}),
    .in_data_d (phase_d == ST_DATA),
    .hit_q     (hit)
  );

  assign cur_addr     = {dw_q, 2'b00};
  assign burst_linear = lin_q;

  // R9, R3: idle never claims and never reports a burst order
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == ST_IDLE) |-> (!hit && !burst_linear));

  // R9: the address holds in idle until a new address phase
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == ST_IDLE && frame_n) |=> $stable(cur_addr));

  // R7: a claim only exists inside a transaction
  p_hit_in_data_r7: assert property (@(posedge clk) disable iff (!srst_n)
    hit |-> (phase_q == ST_DATA));

endmodule

// File: tb/pci_burst_addr_tracker_bench.sv
`timescale 1ns/1ps
module pci_burst_addr_tracker_bench;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int          WLOG = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, trdy_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic [31:0] cur_addr;
  logic        hit, burst_linear;

  int checks   = 0;
  int failures = 0;
  bit running  = 0;

  always #2.5 clk = ~clk;

  pci_burst_addr_tracker #(.WIN_BASE(BASE), .WIN_LOG2(WLOG)) u_pci_burst_addr_tracker (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n),
    .cur_addr(cur_addr), .hit(hit), .burst_linear(burst_linear)
  );

  // Behavioural reference model
  bit          m_active, m_lin, m_mem;
  logic [31:0] m_addr;

  function automatic bit mem_cmd(input logic [3:0] c);
    return (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active <= 0; m_lin <= 0; m_mem <= 0; m_addr <= 32'h0;
    end else if (!m_active) begin
      if (!frame_n) begin
        m_active <= 1;
        m_addr   <= {ad[31:2], 2'b00};
        m_lin    <= (ad[1:0] == 2'b00);
        m_mem    <= mem_cmd(cbe_n);
      end
    end else if (!irdy_n && !trdy_n) begin
      if (m_lin) m_addr <= m_addr + 32'd4;
      if (frame_n) begin
        m_active <= 0;
        m_lin    <= 0;
      end
    end
  end

  function automatic bit m_hit();
    return m_active && m_mem && ((m_addr >> WLOG) == (BASE >> WLOG));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check(m_lin || !m_active ? "R4 cur_addr vs model" : "R6 cur_addr vs model", cur_addr, m_addr);
      check("R7 hit vs model", {31'b0, hit}, {31'b0, m_hit()});
      check("R3 burst_linear vs model", {31'b0, burst_linear}, {31'b0, m_lin});
    end
  end

  task automatic step(input logic f, input logic i, input logic t,
                      input logic [31:0] a, input logic [3:0] c);
    frame_n = f; irdy_n = i; trdy_n = t; ad = a; cbe_n = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_step();
    step(1, 1, 1, 32'h0, 4'h0);
  endtask

  initial begin
    #(5.0 * 50000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; frame_n = 1; irdy_n = 1; trdy_n = 1; ad = 0; cbe_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset cur_addr", cur_addr, 32'h0);
    check("R1 reset hit", {31'b0, hit}, 32'h0);
    check("R1 reset burst_linear", {31'b0, burst_linear}, 32'h0);
    rst_n = 1;
    repeat (4) idle_step();
    running = 1;
    check("R1 after release cur_addr", cur_addr, 32'h0);

    // Linear memory read with wait states from both sides
    step(0, 1, 1, 32'h4000_0100, 4'h6);
    check("R2 captured address", cur_addr, 32'h4000_0100);
    check("R7 hit in window", {31'b0, hit}, 32'h1);
    check("R3 linear code", {31'b0, burst_linear}, 32'h1);
    step(0, 0, 1, 32'hDEAD_0000, 4'h0);
    check("R5 target wait", cur_addr, 32'h4000_0100);
    step(0, 0, 0, 32'hDEAD_0001, 4'h0);
    check("R4 first step", cur_addr, 32'h4000_0104);
    step(0, 1, 0, 32'hDEAD_0002, 4'h0);
    check("R5 initiator wait", cur_addr, 32'h4000_0104);
    step(0, 0, 0, 32'hDEAD_0003, 4'h0);
    check("R4 second step", cur_addr, 32'h4000_0108);
    step(1, 0, 0, 32'hDEAD_0004, 4'h0);
    check("R9 end address", cur_addr, 32'h4000_010C);
    check("R9 end hit", {31'b0, hit}, 32'h0);
    check("R9 end burst_linear", {31'b0, burst_linear}, 32'h0);

    // Back-to-back, non-linear order code 2'b10
    step(0, 1, 1, 32'h4000_0206, 4'h7);
    check("R9 back-to-back capture", cur_addr, 32'h4000_0204);
    check("R3 non-linear code", {31'b0, burst_linear}, 32'h0);
    step(0, 0, 0, 32'h0, 4'h0);
    step(0, 0, 0, 32'h0, 4'h0);
    check("R6 no advance", cur_addr, 32'h4000_0204);
    step(1, 0, 0, 32'h0, 4'h0);
    idle_step();

    // Linear burst leaving the window
    step(0, 1, 1, 32'h4000_0FF8, 4'hC);
    check("R8 start inside", {31'b0, hit}, 32'h1);
    step(0, 0, 0, 32'h0, 4'h0);
    check("R8 last dword inside", {31'b0, hit}, 32'h1);
    step(0, 0, 0, 32'h0, 4'h0);
    check("R8 address past window", cur_addr, 32'h4000_1000);
    check("R8 hit drops", {31'b0, hit}, 32'h0);
    step(1, 0, 0, 32'h0, 4'h0);

    // I/O command inside window
    step(0, 1, 1, 32'h4000_0010, 4'h3);
    check("R10 io no hit", {31'b0, hit}, 32'h0);
    step(0, 0, 0, 32'h0, 4'h0);
    check("R10 io address tracked", cur_addr, 32'h4000_0014);
    check("R10 io still no hit", {31'b0, hit}, 32'h0);
    step(1, 0, 0, 32'h0, 4'h0);

    // Outside the window
    step(0, 1, 1, 32'h5000_0000, 4'h6);
    check("R7 outside no hit", {31'b0, hit}, 32'h0);
    step(1, 0, 0, 32'h0, 4'h0);

    // Wrap at top of address space
    step(0, 1, 1, 32'hFFFF_FFFC, 4'h6);
    step(1, 0, 0, 32'h0, 4'h0);
    check("R11 wrap", cur_addr, 32'h0);

    // Idle with ready strobes active: nothing moves
    step(1, 0, 0, 32'h1234_5678, 4'h6);
    check("R9 idle hold", cur_addr, 32'h0);

    // Random transaction stream checked against the model each clock
    for (int n = 0; n < 60; n++) begin
      int len;
      logic [31:0] a;
      logic [3:0]  c;
      len = 1 + int'($urandom_range(0, 5));
      a   = BASE + 32'($urandom_range(0, 8191)) - 32'd2048;
      c   = 4'($urandom_range(0, 15));
      step(0, 1, 1, a, c);
      for (int k = 0; k < len; k++) begin
        logic last;
        last = (k == len - 1);
        while ($urandom_range(0, 3) == 0)
          step(last, 1'($urandom_range(0, 1)), 1, $urandom, 4'h0);
        step(last, 0, 0, $urandom, 4'h0);
      end
      if ($urandom_range(0, 1) == 1) idle_step();
    end

    repeat (3) idle_step();
    running = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule